// File: doc/BRIEF.md
# CAN Mailbox Interrupt Flag Aggregator

This block keeps the per-mailbox status vectors of a CAN message controller and folds them into two summary interrupt flags. One flag reports that a frame arrived for a mailbox whose previous frame had not yet been taken by the CPU. The other reports that a queued transmission left the mailbox, either sent or aborted, so new data may be loaded. A combined interrupt line is the OR of both.

The receive path presents a one-cycle match pulse per mailbox. The block answers in the same cycle with a store/discard decision for the message RAM, chosen by an overwrite mode bit. The transmit engine reports completions and abort completions as per-mailbox pulses. The CPU reaches the status vectors through a write port: a register select and a 16-bit data word, where a 1 either sets or clears a bit, depending on the register. A per-mailbox mask hides a mailbox from both summary flags.

Top module: `can_mbox_irq`

## Requirements
- R1: A receive pulse for a mailbox whose receive-pending bit is 1 and whose mask bit is 0 sets that mailbox's unread bit on the next clock. If the mask bit is 1, the unread bit is not set.
- R2: `rx_store` for a mailbox with a receive pulse is 1 when its receive-pending bit is 0. When that bit is 1, `rx_store` is 0 with `overwrite_mode`=0 (discard) and 1 with `overwrite_mode`=1 (overwrite).
- R3: `ovr_flag` is 1 exactly when some mailbox has its unread bit at 1 and its mask bit at 0. It reacts to mask changes in the same cycle.
- R4: A CPU write with select 4 clears every unread bit whose data bit is 1. Other unread bits are unchanged.
- R5: `empty_flag` is 1 exactly when some mailbox has its transmit-ack or abort-ack bit at 1 and its mask bit at 0.
- R6: A transmit-complete pulse sets the mailbox's transmit-ack bit and clears its transmit-pending bit. An abort-complete pulse sets the abort-ack bit and clears transmit-pending.
- R7: Reset leaves every status vector and both flags at 0. A CPU write with select 5, where the flag bits sit, or with select 6 or 7, changes no state and no output.
- R8: Select 0 sets transmit-pending bits where data is 1. Selects 1, 2 and 3 clear transmit-ack, abort-ack and receive-pending bits where data is 1. Every receive pulse sets receive-pending.
- R9: When a hardware set event and a CPU write to the same bit land in the same cycle, the bit ends at 1. This holds both when the write clears the bit and when the hardware event clears transmit-pending.
- R10: `irq` equals `ovr_flag` OR `empty_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_hit | input | 16 | Per-mailbox receive match pulse |
| tx_done | input | 16 | Per-mailbox transmit complete pulse |
| abort_done | input | 16 | Per-mailbox abort complete pulse |
| mbox_mask | input | 16 | Per-mailbox interrupt mask, 1 = hidden |
| overwrite_mode | input | 1 | 1 = overwrite unread frame, 0 = discard new frame |
| wr_en | input | 1 | CPU write strobe |
| wr_sel | input | 3 | CPU register select (0..7) |
| wr_data | input | 16 | CPU write data, one bit per mailbox |
| tx_pend | output | 16 | Transmit-pending vector |
| rx_pend | output | 16 | Receive-pending vector |
| unread | output | 16 | Unread-message (overrun/overwrite) vector |
| tx_ack | output | 16 | Transmit-acknowledge vector |
| abort_ack | output | 16 | Abort-acknowledge vector |
| rx_store | output | 16 | Store decision for this cycle's receive pulse |
| ovr_flag | output | 1 | Overrun/overwrite summary flag |
| empty_flag | output | 1 | Mailbox-empty summary flag |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check, on every cycle, the cause-and-effect rules between pulses and status bits:
- an unmasked receive on a pending mailbox leaves its unread bit set;
- a completion leaves its acknowledge bit set and transmit-pending clear;
- a receive pulse always wins over a same-cycle clear;
- discard mode never stores onto a pending mailbox;
- the summary flags stay low while no unmasked bit is set.

The bench scenarios show the parts a property cannot capture well:
- writes to the flag position and to unused selects leave all state untouched;
- masking a set unread bit drops the flag in the same cycle;
- long random mixes of masks, modes and CPU writes keep every vector equal to an independent model.

// File: rtl/can_mbox_irq_pkg.sv
package can_mbox_irq_pkg;
  // CPU register select codes
  typedef enum logic [2:0] {
    SEL_TXREQ  = 3'd0,  // write 1 sets transmit-pending
    SEL_TXACK  = 3'd1,  // write 1 clears transmit-ack
    SEL_ABACK  = 3'd2,  // write 1 clears abort-ack
    SEL_RXPEND = 3'd3,  // write 1 clears receive-pending
    SEL_UNREAD = 3'd4,  // write 1 clears unread status
    SEL_FLAGS  = 3'd5   // summary flags: writes ignored
  } cmi_sel_e;
endpackage

// File: rtl/cmi_bitvec.sv
// Status vector with a hardware set input and a clear input.
// SET_WINS picks which one dominates on a collision.
module cmi_bitvec #(
  parameter int W        = 16,
  parameter bit SET_WINS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r, q_nxt;
  logic         en;

  assign en = (|set_i) | (|clr_i);

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb q_nxt = (q_r & ~clr_i) | set_i;
    end else begin : g_clr_wins
      always_comb q_nxt = (q_r | set_i) & ~clr_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/cmi_rx_check.sv
// Receive-side decision: store or drop, plus overrun event detection.
module cmi_rx_check #(
  parameter int W = 16
) (
  input  logic [W-1:0] rx_hit_i,
  input  logic [W-1:0] rx_pend_i,
  input  logic [W-1:0] mask_i,
  input  logic         overwrite_i,
  output logic [W-1:0] store_o,
  output logic [W-1:0] ovr_evt_o
);
  logic [W-1:0] collide;

  always_comb begin
    collide   = rx_hit_i & rx_pend_i;
    store_o   = rx_hit_i & (~rx_pend_i | {W{overwrite_i}});
    ovr_evt_o = collide & ~mask_i;
  end
endmodule

// File: rtl/cmi_summary.sv
// Summary flags from the status vectors and the mask.
module cmi_summary #(
  parameter int W = 16
) (
  input  logic [W-1:0] unread_i,
  input  logic [W-1:0] tx_ack_i,
  input  logic [W-1:0] ab_ack_i,
  input  logic [W-1:0] mask_i,
  output logic         ovr_o,
  output logic         empty_o,
  output logic         irq_o
);
  logic [W-1:0] vis_unread, vis_done;

  always_comb begin
    vis_unread = unread_i & ~mask_i;
    vis_done   = (tx_ack_i | ab_ack_i) & ~mask_i;
    ovr_o      = |vis_unread;
    empty_o    = |vis_done;
    irq_o      = ovr_o | empty_o;
  end
endmodule

// File: rtl/can_mbox_irq.sv
module can_mbox_irq
  import can_mbox_irq_pkg::*;
#(
  parameter int NMB = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NMB-1:0] rx_hit,
  input  logic [NMB-1:0] tx_done,
  input  logic [NMB-1:0] abort_done,
  input  logic [NMB-1:0] mbox_mask,
  input  logic           overwrite_mode,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [NMB-1:0] wr_data,
  output logic [NMB-1:0] tx_pend,
  output logic [NMB-1:0] rx_pend,
  output logic [NMB-1:0] unread,
  output logic [NMB-1:0] tx_ack,
  output logic [NMB-1:0] abort_ack,
  output logic [NMB-1:0] rx_store,
  output logic           ovr_flag,
  output logic           empty_flag,
  output logic           irq
);
  localparam int NSEL = 5;  // writable selects 0..4

  logic [NSEL-1:0][NMB-1:0] wr_vec;
  logic [NMB-1:0]           tx_fin;
  logic [NMB-1:0]           ovr_evt;

  // write strobes decoded per select; select 5 and above fall through
  generate
    for (genvar s = 0; s < NSEL; s++) begin : g_wdec
      assign wr_vec[s] = (wr_en && (wr_sel == 3'(s))) ? wr_data : '0;
    end
  endgenerate

  assign tx_fin = tx_done | abort_done;

  cmi_rx_check #(.W(NMB)) u_rx (
    .rx_hit_i    (rx_hit),
    .rx_pend_i   (rx_pend),
    .mask_i      (mbox_mask),
    .overwrite_i (overwrite_mode),
    .store_o     (rx_store),
    .ovr_evt_o   (ovr_evt)
  );

  // CPU request set wins over a same-cycle completion
  cmi_bitvec #(.W(NMB), .SET_WINS(1'b1)) u_txp (
    .clk(clk), .rst_n(rst_n),
    .set_i(wr_vec[SEL_TXREQ]), .clr_i(tx_fin), .q_o(tx_pend));

  cmi_bitvec #(.W(NMB), .SET_WINS(1'b1)) u_txa (
    .clk(clk), .rst_n(rst_n),
    .set_i(tx_done), .clr_i(wr_vec[SEL_TXACK]), .q_o(tx_ack));

  cmi_bitvec #(.W(NMB), .SET_WINS(1'b1)) u_aba (
    .clk(clk), .rst_n(rst_n),
    .set_i(abort_done), .clr_i(wr_vec[SEL_ABACK]), .q_o(abort_ack));

  cmi_bitvec #(.W(NMB), .SET_WINS(1'b1)) u_rxp (
    .clk(clk), .rst_n(rst_n),
    .set_i(rx_hit), .clr_i(wr_vec[SEL_RXPEND]), .q_o(rx_pend));

  cmi_bitvec #(.W(NMB), .SET_WINS(1'b1)) u_unr (
    .clk(clk), .rst_n(rst_n),
    .set_i(ovr_evt), .clr_i(wr_vec[SEL_UNREAD]), .q_o(unread));

  cmi_summary #(.W(NMB)) u_sum (
    .unread_i (unread),
    .tx_ack_i (tx_ack),
    .ab_ack_i (abort_ack),
    .mask_i   (mbox_mask),
    .ovr_o    (ovr_flag),
    .empty_o  (empty_flag),
    .irq_o    (irq)
  );
endmodule

// File: rtl/can_mbox_irq_chk.sv
module can_mbox_irq_chk #(
  parameter int NMB = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NMB-1:0] rx_hit,
  input logic [NMB-1:0] tx_done,
  input logic [NMB-1:0] abort_done,
  input logic [NMB-1:0] mbox_mask,
  input logic           overwrite_mode,
  input logic [NMB-1:0] tx_pend,
  input logic [NMB-1:0] rx_pend,
  input logic [NMB-1:0] unread,
  input logic [NMB-1:0] tx_ack,
  input logic [NMB-1:0] abort_ack,
  input logic [NMB-1:0] rx_store,
  input logic           ovr_flag,
  input logic           empty_flag,
  input logic           irq
);
  logic [NMB-1:0] ovr_cause;
  assign ovr_cause = rx_hit & rx_pend & ~mbox_mask;

  p_unread_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovr_cause) |=> ((unread & $past(ovr_cause)) == $past(ovr_cause)));

  p_discard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!overwrite_mode) |-> ((rx_store & rx_pend) == '0));

  p_ovr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((unread & ~mbox_mask) == '0) |-> !ovr_flag);

  p_empty_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((tx_ack | abort_ack) & ~mbox_mask) == '0) |-> !empty_flag);

  p_txdone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|tx_done) |=> ((tx_ack & $past(tx_done)) == $past(tx_done)));

  p_abdone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|abort_done) |=> ((abort_ack & $past(abort_done)) == $past(abort_done)));

  p_rx_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_hit) |=> ((rx_pend & $past(rx_hit)) == $past(rx_hit)));

  p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag || empty_flag) |-> irq);
endmodule

bind can_mbox_irq can_mbox_irq_chk #(.NMB(NMB)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_hit(rx_hit), .tx_done(tx_done),
  .abort_done(abort_done), .mbox_mask(mbox_mask),
  .overwrite_mode(overwrite_mode), .tx_pend(tx_pend), .rx_pend(rx_pend),
  .unread(unread), .tx_ack(tx_ack), .abort_ack(abort_ack),
  .rx_store(rx_store), .ovr_flag(ovr_flag), .empty_flag(empty_flag),
  .irq(irq)
);

// File: tb/sim_can_mbox_irq.sv
module sim_can_mbox_irq;
  localparam int N = 16;

  logic         clk, rst_n;
  logic [N-1:0] rx_hit, tx_done, abort_done, mbox_mask, wr_data;
  logic         overwrite_mode, wr_en;
  logic [2:0]   wr_sel;
  logic [N-1:0] tx_pend, rx_pend, unread, tx_ack, abort_ack, rx_store;
  logic         ovr_flag, empty_flag, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [N-1:0] m_txp, m_rxp, m_un, m_ta, m_aa;

  can_mbox_irq #(.NMB(N)) u0 (.*);

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] wv(logic we, logic [2:0] sel, logic [2:0] want,
                                      logic [N-1:0] d);
    return (we && sel == want) ? d : '0;
  endfunction

  task automatic step(logic [N-1:0] rh, logic [N-1:0] td, logic [N-1:0] ad,
                      logic [N-1:0] mk, logic ow, logic we, logic [2:0] sel,
                      logic [N-1:0] wd);
    logic [N-1:0] e_store;
    logic         e_ovr, e_emp;
    @(negedge clk);
    rx_hit = rh; tx_done = td; abort_done = ad; mbox_mask = mk;
    overwrite_mode = ow; wr_en = we; wr_sel = sel; wr_data = wd;
    #1;
    e_store = rh & (~m_rxp | {N{ow}});
    e_ovr   = |(m_un & ~mk);
    e_emp   = |((m_ta | m_aa) & ~mk);
    chk("R8 tx_pend",   tx_pend,   m_txp);
    chk("R8 rx_pend",   rx_pend,   m_rxp);
    chk("R1 R4 unread", unread,    m_un);
    chk("R6 tx_ack",    tx_ack,    m_ta);
    chk("R6 abort_ack", abort_ack, m_aa);
    chk("R2 rx_store",  rx_store,  e_store);
    chk("R3 ovr_flag",  N'(ovr_flag),   N'(e_ovr));
    chk("R5 empty_flag", N'(empty_flag), N'(e_emp));
    chk("R10 irq",      N'(irq),   N'(e_ovr | e_emp));
    // advance model to the state after the coming edge (set wins, R9)
    m_txp = (m_txp & ~(td | ad)) | wv(we, sel, 3'd0, wd);
    m_ta  = (m_ta  & ~wv(we, sel, 3'd1, wd)) | td;
    m_aa  = (m_aa  & ~wv(we, sel, 3'd2, wd)) | ad;
    m_un  = (m_un  & ~wv(we, sel, 3'd4, wd)) | (rh & m_rxp & ~mk);
    m_rxp = (m_rxp & ~wv(we, sel, 3'd3, wd)) | rh;
  endtask

  task automatic idle(logic [N-1:0] mk);
    step('0, '0, '0, mk, 1'b0, 1'b0, 3'd0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    m_txp = '0; m_rxp = '0; m_un = '0; m_ta = '0; m_aa = '0;
    rst_n = 0; rx_hit = '0; tx_done = '0; abort_done = '0; mbox_mask = '0;
    overwrite_mode = 0; wr_en = 0; wr_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 reset vectors", tx_pend | rx_pend | unread | tx_ack | abort_ack, '0);
    chk("R7 reset flags", N'({ovr_flag, empty_flag, irq}), '0);
    rst_n = 1;

    // R1: second frame on pending mailbox 3, discard mode
    step(16'h0008, '0, '0, '0, 1'b0, 1'b0, 3'd0, '0);
    step(16'h0008, '0, '0, '0, 1'b0, 1'b0, 3'd0, '0);
    chk("R2 discard", rx_store, '0);
    idle('0);
    chk("R1 unread bit3", unread, 16'h0008);
    chk("R1 ovr_flag", N'(ovr_flag), N'(1));
    // R7: write to flag select and unused selects has no effect
    step('0, '0, '0, '0, 1'b0, 1'b1, 3'd5, 16'hFFFF);
    step('0, '0, '0, '0, 1'b0, 1'b1, 3'd7, 16'hFFFF);
    idle('0);
    chk("R7 unread kept", unread, 16'h0008);
    chk("R7 rx_pend kept", rx_pend, 16'h0008);
    chk("R7 flag kept", N'(ovr_flag), N'(1));
    // R3: masking the only unread mailbox drops the flag now
    idle(16'h0008);
    chk("R3 masked flag", N'(ovr_flag), N'(0));
    // R2: overwrite mode stores onto pending mailbox
    step(16'h0008, '0, '0, 16'h0008, 1'b1, 1'b0, 3'd0, '0);
    chk("R2 overwrite", rx_store, 16'h0008);
    // R9: receive pulse against rx_pend clear on same bit
    step(16'h0008, '0, '0, '0, 1'b0, 1'b1, 3'd3, 16'h0008);
    idle('0);
    chk("R9 rx_pend set wins", rx_pend, 16'h0008);
    // R9: tx request write against completion on same bit
    step('0, 16'h0100, '0, '0, 1'b0, 1'b1, 3'd0, 16'h0100);
    idle('0);
    chk("R9 tx_pend request wins", tx_pend, 16'h0100);
    chk("R5 empty_flag", N'(empty_flag), N'(1));
    // R4: clear unread bit3
    step('0, '0, '0, '0, 1'b0, 1'b1, 3'd4, 16'h0008);
    idle('0);
    chk("R4 unread cleared", unread, '0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] rh, td, ad, mk, wd;
      logic [2:0] sel;
      rh  = N'($urandom) & N'($urandom) & N'($urandom);
      td  = N'($urandom) & N'($urandom) & N'($urandom);
      ad  = N'($urandom) & N'($urandom) & N'($urandom) & N'($urandom);
      mk  = ((i / 64) % 3 == 0) ? '0 : N'($urandom) & N'($urandom);
      wd  = N'($urandom);
      sel = 3'($urandom_range(0, 7));
      step(rh, td, ad, mk, 1'($urandom), 1'($urandom), sel, wd);
    end
    finish_run();
  end
endmodule